// File: doc/BRIEF.md
# Four-Channel Programmable Timer Bank

This block holds four independent down-counting timers behind a small word-addressed register port. Two timers are 16 bits wide and two are 32 bits wide. Each timer runs from one of four tick rates. All four rates come from a single 2 MHz reference tick, which a shared free-running divider splits down. Software writes a reload value for each timer, then sets the timer's enable bit. From then on the timer counts down once per selected tick, signals a timeout when it passes zero, and restarts from its reload value.

One 32-bit control/status word gives each timer a byte of its own. That byte holds the timer's enable, its interrupt enable, its 2-bit rate code and a sticky flag that records that the timer raised the interrupt. The block ORs the flags whose interrupt enable is set and drives the result on one registered interrupt line. After the line rises, software reads the control/status word to see which timer fired, then writes 0 to that flag to clear it.

The count registers are read-only. A read returns its data on `rdata` one clock after `rd_en` is sampled. A write takes effect at the clock edge where `wr_en` is sampled.

Top module: `timer_bank`

## Requirements
- R1: A synchronous reset clears the control/status word, every reload value, every count, `irq` and `rdata` to 0.
- R2: Word address 0 is the control/status word. Addresses 1 to 4 are the reload values of timers 1 to 4. Addresses 5 to 8 are the current counts of timers 1 to 4 and ignore writes. Any other address reads as 0. `rdata` carries the value held before the sampling edge, and it is valid from that edge on.
- R3: Timer k (1..4) owns bits [8k-1:8k-8] of the control/status word. Inside that byte, bit 0 is the cause flag, bit 1 is the enable, bit 2 is the interrupt enable and bits 4:3 are the rate code. All 32 bits, reserved ones included, store the value written and read it back.
- R4: Timers 1 and 2 keep only bits 15:0 of a reload write, and they read their reload and count zero-extended. Timers 3 and 4 keep all 32 bits.
- R5: Rate code 00 advances the timer on every reference tick. Code 01 advances it on every 2nd tick, 10 on every 4th and 11 on every 8th. A timer using code c advances on the reference ticks whose index since reset, counted from 0, leaves a remainder of 2^c-1 when divided by 2^c.
- R6: A control/status write that takes a timer's enable from 0 to 1 loads the timer's count from its reload value at that edge.
- R7: While a timer is enabled, each of its ticks decrements a nonzero count. A count of 0 instead produces a timeout and reloads the count on the same tick.
- R8: While a timer's enable is 0, its count holds.
- R9: A timeout sets the timer's cause flag only if its interrupt enable is 1. With the interrupt enable at 0, a timeout leaves the flag unchanged.
- R10: A control/status write stores the written value into each cause flag, so writing 0 clears it. When a timeout and a write of 0 to the same flag fall in the same cycle, the flag stays 1.
- R11: `irq` is a registered output equal to the OR, over all timers, of cause flag AND interrupt enable. It changes at the same edge as the control/status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Single-cycle pulse at the 2 MHz reference rate |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Combined interrupt, registered |

## Verification
Written register state, loaded counts, timer decrements, cause flags and `irq` all change at the edge that samples the stimulus. Read data follows one edge after `rd_en` and reports the state held before that edge. The bench drives stimulus at a falling edge and updates its reference model at the next rising edge. It then compares `irq` and any pending `rdata` at the following falling edge, so every result is sampled exactly one edge after its cause. The bench tracks the reference-tick index from reset, so the divider phase behind each rate code is predicted. The directed rate check uses 16 reference ticks, a multiple of every divider period, so its expected counts do not depend on that phase.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;

  // layout of one timer's byte in the control/status word
  localparam int SLOT_W   = 8;
  localparam int FLAG_BIT = 0;
  localparam int EN_BIT   = 1;
  localparam int IE_BIT   = 2;
  localparam int SEL_LSB  = 3;
  localparam int SEL_W    = 2;

  // narrow timers come first in the bank
  function automatic int lane_width(input int idx, input int n_narrow,
                                    input int narrow_w, input int wide_w);
    return (idx < n_narrow) ? narrow_w : wide_w;
  endfunction

endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int NUM_RATES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ref_tick,
  output logic [NUM_RATES-1:0] rate_tick
);

  localparam int PH_W = (NUM_RATES > 1) ? NUM_RATES - 1 : 1;

  logic [PH_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst)
      phase <= '0;
    else if (ref_tick)
      phase <= phase + 1'b1;
  end

  assign rate_tick[0] = ref_tick;

  // tap k fires on the last reference tick of every 2^k
  for (genvar k = 1; k < NUM_RATES; k++) begin : g_tap
    assign rate_tick[k] = ref_tick & (&phase[k-1:0]);
  end

endmodule

// File: rtl/countdown_timer.sv
module countdown_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             start,
  input  logic             reload_we,
  input  logic [CNT_W-1:0] reload_wd,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] reload_val,
  output logic             timeout
);

  assign timeout = run & tick & (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_val <= '0;
      count      <= '0;
    end else begin
      if (reload_we)
        reload_val <= reload_wd;
      if (start)
        count <= reload_val;
      else if (run && tick) begin
        if (count == '0)
          count <= reload_val;
        else
          count <= count - 1'b1;
      end
    end
  end

endmodule

// File: rtl/timer_bank.sv
module timer_bank
  import timer_bank_pkg::*;
#(
  parameter int NUM_TIMERS = 4,
  parameter int NUM_NARROW = 2,
  parameter int NARROW_W   = 16,
  parameter int WIDE_W     = 32,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  localparam int NUM_RATES  = 1 << SEL_W;
  localparam int RELOAD_LO  = 1;
  localparam int COUNT_LO   = 1 + NUM_TIMERS;

  logic [DATA_W-1:0]    csr, csr_n;
  logic                 irq_n;
  logic [NUM_RATES-1:0] rate_tick;
  logic [NUM_TIMERS-1:0] t_en, t_ie, t_tick, t_start, t_timeout;
  logic [DATA_W-1:0]    rl_word  [NUM_TIMERS];
  logic [DATA_W-1:0]    cnt_word [NUM_TIMERS];
  logic [DATA_W-1:0]    rd_mux;
  logic                 wr_csr;

  assign wr_csr = wr_en && (addr == '0);

  tick_divider #(.NUM_RATES(NUM_RATES)) u_div (
    .clk       (clk),
    .rst       (rst),
    .ref_tick  (ref_tick),
    .rate_tick (rate_tick)
  );

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_lane
    localparam int W = lane_width(i, NUM_NARROW, NARROW_W, WIDE_W);
    logic [W-1:0]     cnt_w, rl_w;
    logic [SEL_W-1:0] sel;

    assign t_en[i]    = csr[SLOT_W*i + EN_BIT];
    assign t_ie[i]    = csr[SLOT_W*i + IE_BIT];
    assign sel        = csr[SLOT_W*i + SEL_LSB +: SEL_W];
    assign t_tick[i]  = rate_tick[sel];
    assign t_start[i] = wr_csr && wdata[SLOT_W*i + EN_BIT] && !t_en[i];

    countdown_timer #(.CNT_W(W)) u_tmr (
      .clk        (clk),
      .rst        (rst),
      .run        (t_en[i]),
      .tick       (t_tick[i]),
      .start      (t_start[i]),
      .reload_we  (wr_en && (addr == ADDR_W'(RELOAD_LO + i))),
      .reload_wd  (wdata[W-1:0]),
      .count      (cnt_w),
      .reload_val (rl_w),
      .timeout    (t_timeout[i])
    );

    assign cnt_word[i] = DATA_W'(cnt_w);
    assign rl_word[i]  = DATA_W'(rl_w);
  end

  // next control/status word: write first, timeout sets win over it
  always_comb begin
    csr_n = wr_csr ? wdata : csr;
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (t_timeout[i] && t_ie[i])
        csr_n[SLOT_W*i + FLAG_BIT] = 1'b1;
    end
    irq_n = 1'b0;
    for (int i = 0; i < NUM_TIMERS; i++)
      irq_n = irq_n | (csr_n[SLOT_W*i + FLAG_BIT] & csr_n[SLOT_W*i + IE_BIT]);
  end

  always_comb begin
    rd_mux = '0;
    if (addr == '0)
      rd_mux = csr;
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (addr == ADDR_W'(RELOAD_LO + i))
        rd_mux = rl_word[i];
      if (addr == ADDR_W'(COUNT_LO + i))
        rd_mux = cnt_word[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csr   <= '0;
      irq   <= 1'b0;
      rdata <= '0;
    end else begin
      csr <= csr_n;
      irq <= irq_n;
      if (rd_en)
        rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/timer_bank_checker.sv
module timer_bank_checker
  import timer_bank_pkg::*;
#(
  parameter int NUM_TIMERS = 4,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic              irq,
  input logic [DATA_W-1:0] csr
);

  localparam int LAST_ADDR = 2 * NUM_TIMERS;

  logic                  wr_csr;
  logic [NUM_TIMERS-1:0] pend;
  logic [DATA_W-1:0]     flag_mask;

  assign wr_csr = wr_en && (addr == '0);

  always_comb begin
    flag_mask = '0;
    for (int i = 0; i < NUM_TIMERS; i++)
      flag_mask[SLOT_W*i + FLAG_BIT] = 1'b1;
  end

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_chk
    assign pend[i] = csr[SLOT_W*i + FLAG_BIT] & csr[SLOT_W*i + IE_BIT];

    // R10: without a write a set flag never falls
    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (rst)
      (!wr_csr && csr[SLOT_W*i + FLAG_BIT]) |=> csr[SLOT_W*i + FLAG_BIT]);

    // R9: a flag cannot rise by itself while its interrupt enable is 0
    a_r9_flag_needs_ie: assert property (@(posedge clk) disable iff (rst)
      (!wr_csr && !csr[SLOT_W*i + FLAG_BIT] && !csr[SLOT_W*i + IE_BIT])
      |=> !csr[SLOT_W*i + FLAG_BIT]);
  end

  // R3: non-flag bits change only through a write
  a_r3_hold_unwritten: assert property (@(posedge clk) disable iff (rst)
    !wr_csr |=> ((csr & ~flag_mask) == $past(csr & ~flag_mask)));

  // R11: interrupt line agrees with the flag/enable pairs
  a_r11_irq_tracks: assert property (@(posedge clk) disable iff (rst)
    irq == (|pend));

  // R2: unmapped addresses read as zero
  a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (addr > ADDR_W'(LAST_ADDR))) |=> (rdata == '0));

  // R1: reset clears the visible state
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (csr == '0 && !irq && rdata == '0));

endmodule

bind timer_bank timer_bank_checker #(
  .NUM_TIMERS (NUM_TIMERS),
  .DATA_W     (DATA_W),
  .ADDR_W     (ADDR_W)
) u_chk (
  .clk   (clk),
  .rst   (rst),
  .wr_en (wr_en),
  .rd_en (rd_en),
  .addr  (addr),
  .rdata (rdata),
  .irq   (irq),
  .csr   (csr)
);

// File: tb/timer_bank_test.sv
`timescale 1ns/1ps
module timer_bank_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  always #4 clk = ~clk;

  timer_bank uut (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  int n_chk = 0;
  int n_bad = 0;

  // reference model, built from the requirements
  logic [31:0] m_csr;
  logic [31:0] m_rl  [4];
  logic [31:0] m_cnt [4];
  logic        m_irq;
  int unsigned m_ref;

  function automatic logic [31:0] lane_mask(input int i);
    return (i < 2) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] model_read(input logic [3:0] a);
    if (a == 4'd0) return m_csr;
    if (a >= 4'd1 && a <= 4'd4) return m_rl[a - 4'd1];
    if (a >= 4'd5 && a <= 4'd8) return m_cnt[a - 4'd5];
    return 32'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, model at rising edge, check at next falling edge
  task automatic step(input logic wr, input logic rd, input logic [3:0] a,
                      input logic [31:0] d, input logic rt);
    logic [31:0] exp_rd;
    logic [31:0] nxt;
    wr_en = wr; rd_en = rd; addr = a; wdata = d; ref_tick = rt;
    exp_rd = model_read(a);
    @(posedge clk);
    nxt = (wr && a == 4'd0) ? d : m_csr;
    for (int i = 0; i < 4; i++) begin
      int unsigned per;
      logic en, ie, tk, to;
      en  = m_csr[8*i+1];
      ie  = m_csr[8*i+2];
      per = 32'd1 << m_csr[8*i+3 +: 2];
      tk  = rt && ((m_ref % per) == per - 1);
      to  = 1'b0;
      if (wr && a == 4'd0 && d[8*i+1] && !en)
        m_cnt[i] = m_rl[i];
      else if (en && tk) begin
        if (m_cnt[i] == 0) begin
          to = 1'b1;
          m_cnt[i] = m_rl[i];
        end else
          m_cnt[i] = m_cnt[i] - 1;
      end
      if (to && ie) nxt[8*i] = 1'b1;
      if (wr && a == 4'(1 + i)) m_rl[i] = d & lane_mask(i);
    end
    m_csr = nxt;
    if (rt) m_ref++;
    m_irq = 1'b0;
    for (int i = 0; i < 4; i++) m_irq = m_irq | (m_csr[8*i] & m_csr[8*i+2]);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R11 irq", {31'd0, irq}, {31'd0, m_irq});
    if (rd) chk("R2 read data", rdata, exp_rd);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic rt);
    step(1'b1, 1'b0, a, d, rt);
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
    step(1'b0, 1'b1, a, 32'h0, 1'b0);
    chk(tag, rdata, exp);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) step(1'b0, 1'b0, 4'd0, 32'h0, 1'b1);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R1..: actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    m_csr = '0; m_irq = 1'b0; m_ref = 0;
    for (int i = 0; i < 4; i++) begin m_rl[i] = '0; m_cnt[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    chk("R1 rdata after reset", rdata, 32'd0);
    rd_chk(4'd0, 32'h0, "R1 csr after reset");
    rd_chk(4'd1, 32'h0, "R1 reload after reset");
    rd_chk(4'd8, 32'h0, "R1 count after reset");

    // R4 widths
    wr(4'd1, 32'h1234_5678, 1'b0);
    rd_chk(4'd1, 32'h0000_5678, "R4 narrow reload");
    wr(4'd3, 32'h1234_5678, 1'b0);
    rd_chk(4'd3, 32'h1234_5678, "R4 wide reload");

    // R3 reserved bits store
    wr(4'd0, 32'hE0E0_E0E0, 1'b0);
    rd_chk(4'd0, 32'hE0E0_E0E0, "R3 reserved bits");
    wr(4'd0, 32'h0, 1'b0);

    // R6/R7/R9: timer 1, reload 3, rate 00, interrupt on
    wr(4'd1, 32'd3, 1'b0);
    wr(4'd0, 32'h0000_0006, 1'b0);
    rd_chk(4'd5, 32'd3, "R6 load on enable");
    ticks(3);
    chk("R7 no timeout before zero", {31'd0, irq}, 32'd0);
    ticks(1);
    chk("R9 timeout raises irq", {31'd0, irq}, 32'd1);
    rd_chk(4'd0, 32'h0000_0007, "R9 flag set");
    rd_chk(4'd5, 32'd3, "R7 reload on timeout");

    // R10 clear racing a timeout
    wr(4'd0, 32'h0000_0006, 1'b1);
    ticks(2);
    wr(4'd0, 32'h0000_0006, 1'b1);
    rd_chk(4'd0, 32'h0000_0007, "R10 timeout beats clear");
    wr(4'd0, 32'h0000_0006, 1'b0);
    rd_chk(4'd0, 32'h0000_0006, "R10 clear by writing 0");
    chk("R10 irq low after clear", {31'd0, irq}, 32'd0);

    // R8 disabled count holds
    wr(4'd0, 32'h0, 1'b0);
    rd_chk(4'd5, 32'd3, "R8 count before idle ticks");
    ticks(8);
    rd_chk(4'd5, 32'd3, "R8 count held");

    // R9 no flag without interrupt enable
    wr(4'd2, 32'd0, 1'b0);
    wr(4'd0, 32'h0000_0200, 1'b0);
    ticks(3);
    rd_chk(4'd0, 32'h0000_0200, "R9 no flag when ie=0");

    // R5 rate codes 01 and 11 over 16 reference ticks
    wr(4'd3, 32'd100, 1'b0);
    wr(4'd4, 32'd100, 1'b0);
    wr(4'd0, 32'h1A0A_0000, 1'b0);
    ticks(16);
    rd_chk(4'd7, 32'd92, "R5 rate code 01");
    rd_chk(4'd8, 32'd98, "R5 rate code 11");

    // R2 unmapped and read-only addresses
    rd_chk(4'd12, 32'h0, "R2 unmapped read");
    wr(4'd6, 32'hFFFF, 1'b0);
    rd_chk(4'd6, 32'd0, "R2 count ignores write");
    wr(4'd0, 32'h0, 1'b0);

    // constrained random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      int unsigned r;
      logic rt;
      r  = $urandom % 100;
      rt = ($urandom % 10) < 7;
      if (r < 8)
        step(1'b1, 1'b0, 4'd0, $urandom, rt);
      else if (r < 16)
        step(1'b1, 1'b0, 4'(1 + $urandom % 4),
             (($urandom % 20) == 0) ? $urandom : ($urandom % 8), rt);
      else if (r < 40)
        step(1'b0, 1'b1, 4'($urandom % 12), 32'h0, rt);
      else
        step(1'b0, 1'b0, 4'd0, 32'h0, rt);
    end

    finish_run();
  end

endmodule